// File: doc/BRIEF.md
# Windowed Coarse-Sync Timing Chain

This block turns a fast oscillator tick into a one-second square wave and a companion clock at twice that rate. Around the falling edge of the one-second wave it opens an acceptance window of configurable half-width, measured in oscillator ticks. A reference pulse that lands inside the window is passed on, one cycle later, to the early/late phase detector. A pulse that lands outside it is held back and counted.

The block counts out-of-window pulses in a row. When that run reaches a configured limit, the divider is re-phased so that the falling edge of the one-second wave falls on the tick at which the offending pulse arrived. The second in progress is shortened, and later pulses fall inside the window. Any single in-window pulse clears the run. A second with no pulse leaves the run unchanged, so losing the reference alone never re-phases the chain.

All logic runs on one system clock. The oscillator tick and the reference pulse are one-cycle strobes on that clock.

Top module: `coarse_sync_timer`

## Requirements
- R1: After synchronous reset the phase is zero. `sec_clk` and `dbl_clk` are low, `win_open` is high, `miss_count` is 0, and `fwd_pulse` and `resync` are low.
- R2: The phase advances by one on each cycle with `osc_tick` high, wrapping from TICKS_PER_SEC-1 to 0. `sec_clk` is low for phases below TICKS_PER_SEC/2 and high otherwise, so its falling edge is the wrap to phase 0.
- R3: `dbl_clk` has period TICKS_PER_SEC/2. It is low in the first quarter-period of each half of the second and high in the second quarter.
- R4: `win_open` is high exactly when the phase is at most HALF_WIN ticks after the falling edge or at most HALF_WIN ticks before it: phase <= HALF_WIN or phase >= TICKS_PER_SEC-HALF_WIN.
- R5: A `ref_pulse` seen while `win_open` is high raises `fwd_pulse` for one cycle in the next cycle and sets `miss_count` to 0.
- R6: A `ref_pulse` seen while `win_open` is low is not forwarded. It raises `miss_count` by one, unless that would reach MISS_LIMIT.
- R7: The out-of-window pulse that would bring `miss_count` to MISS_LIMIT re-phases the chain instead. In the next cycle the phase is 0, `miss_count` is 0, `resync` is high for one cycle and `fwd_pulse` stays low.
- R8: On a cycle with no `ref_pulse`, `miss_count` keeps its value, however long the reference is absent.
- R9: When a re-phase and an oscillator tick fall in the same cycle, the re-phase wins: the phase becomes 0, not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator tick |
| ref_pulse | input | 1 | One-cycle strobe at the reference pulse leading edge |
| sec_clk | output | 1 | Divided one-second clock |
| dbl_clk | output | 1 | Clock at twice the rate of sec_clk |
| win_open | output | 1 | Acceptance window around the sec_clk falling edge |
| fwd_pulse | output | 1 | Reference pulse passed to the phase detector |
| miss_count | output | MISS_W | Consecutive out-of-window pulse count |
| resync | output | 1 | One-cycle flag when the divider is re-phased |

## Verification
The assertions assume that `ref_pulse` and `osc_tick` are single-cycle strobes synchronous to `clk`. They also assume that the window half-width is well below a quarter of the period, so the window never touches the rising edge of `sec_clk`. The stimulus raises each pulse for exactly one cycle. It places pulses at chosen phases: on the window edges, just outside them, and in runs of misses. Between pulses it uses both dense and sparse tick patterns, and it includes a re-phase that coincides with a tick.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [1:0] {
        PV_NONE = 2'd0,
        PV_HIT  = 2'd1,
        PV_MISS = 2'd2
    } pulse_verdict_e;

    typedef struct packed {
        logic sec;
        logic dbl;
    } clk_pair_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic logic phase_in_window(input int unsigned ph,
                                             input int unsigned period,
                                             input int unsigned hw);
        return (ph <= hw) || (ph >= period - hw);
    endfunction

endpackage

// File: rtl/tc_divider.sv
module tc_divider
    import tc_pkg::*;
#(
    parameter int unsigned PERIOD = 1000,
    parameter int unsigned PH_W   = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            load,
    output logic [PH_W-1:0] phase,
    output clk_pair_t       clks
);
    localparam int unsigned HALF  = PERIOD / 2;
    localparam int unsigned QUART = PERIOD / 4;
    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            phase <= '0;
        end else if (tick) begin
            phase <= (phase == LAST) ? '0 : phase + PH_W'(1);
        end
    end

    generate
        if ((PERIOD & (PERIOD - 1)) == 0) begin : g_pow2
            assign clks.sec = phase[PH_W-1];
            assign clks.dbl = phase[PH_W-2];
        end else begin : g_cmp
            always_comb begin
                clks.sec = (phase >= PH_W'(HALF));
                clks.dbl = ((phase >= PH_W'(QUART)) && (phase < PH_W'(HALF)))
                        || (phase >= PH_W'(HALF + QUART));
            end
        end
    endgenerate

    // R2: phase stays in range and wraps on the last tick
    a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && phase == LAST) |=> (phase == '0));
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(phase));
    // R7 / R9: a re-phase request forces phase zero, even with a tick
    a_r7_load_zero: assert property (@(posedge clk) disable iff (rst)
        load |=> (phase == '0));
    a_r9_load_beats_tick: assert property (@(posedge clk) disable iff (rst)
        (load && tick) |=> !clks.sec);
endmodule

// File: rtl/tc_window_gate.sv
module tc_window_gate
    import tc_pkg::*;
#(
    parameter int unsigned PERIOD   = 1000,
    parameter int unsigned HALF_WIN = 2,
    parameter int unsigned PH_W     = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] phase,
    input  logic            ref_pulse,
    output logic            win_open,
    output pulse_verdict_e  verdict,
    output logic            fwd_q
);
    always_comb begin
        win_open = phase_in_window(32'(phase), PERIOD, HALF_WIN);
        if (!ref_pulse)    verdict = PV_NONE;
        else if (win_open) verdict = PV_HIT;
        else               verdict = PV_MISS;
    end

    always_ff @(posedge clk) begin
        if (rst) fwd_q <= 1'b0;
        else     fwd_q <= (verdict == PV_HIT);
    end

    // R5: a forwarded pulse always came from inside the window
    a_r5_fwd_from_window: assert property (@(posedge clk) disable iff (rst)
        fwd_q |-> $past(ref_pulse && win_open));
    // R6: an outside pulse is never forwarded
    a_r6_miss_not_fwd: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse && !win_open) |=> !fwd_q);
endmodule

// File: rtl/tc_miss_tracker.sv
module tc_miss_tracker
    import tc_pkg::*;
#(
    parameter int unsigned MISS_LIMIT = 4,
    parameter int unsigned MISS_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  pulse_verdict_e    verdict,
    output logic [MISS_W-1:0] miss_q,
    output logic              load,
    output logic              resync_q
);
    localparam logic [MISS_W-1:0] TOP = MISS_W'(MISS_LIMIT - 1);

    always_comb begin
        load = (verdict == PV_MISS) && (miss_q == TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            miss_q   <= '0;
            resync_q <= 1'b0;
        end else begin
            resync_q <= load;
            unique case (verdict)
                PV_HIT:  miss_q <= '0;
                PV_MISS: miss_q <= load ? '0 : miss_q + MISS_W'(1);
                default: miss_q <= miss_q;
            endcase
        end
    end

    // R8: no pulse, no change to the miss count
    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        (verdict == PV_NONE) |=> $stable(miss_q));
    // R5: an in-window pulse clears the count
    a_r5_hit_clears: assert property (@(posedge clk) disable iff (rst)
        (verdict == PV_HIT) |=> (miss_q == '0));
    // R7: the count never reaches the limit
    a_r7_below_limit: assert property (@(posedge clk) disable iff (rst)
        miss_q < MISS_W'(MISS_LIMIT));
    // R7: resync is followed by a cleared count
    a_r7_resync_clear: assert property (@(posedge clk) disable iff (rst)
        resync_q |-> (miss_q == '0));
endmodule

// File: rtl/coarse_sync_timer.sv
module coarse_sync_timer
    import tc_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 1000,
    parameter int unsigned HALF_WIN      = 2,
    parameter int unsigned MISS_LIMIT    = 4,
    localparam int unsigned PH_W   = cnt_width(TICKS_PER_SEC),
    localparam int unsigned MISS_W = cnt_width(MISS_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic              ref_pulse,
    output logic              sec_clk,
    output logic              dbl_clk,
    output logic              win_open,
    output logic              fwd_pulse,
    output logic [MISS_W-1:0] miss_count,
    output logic              resync
);
    logic [PH_W-1:0] phase;
    clk_pair_t       clks;
    pulse_verdict_e  verdict;
    logic            load;

    tc_divider #(.PERIOD(TICKS_PER_SEC), .PH_W(PH_W)) u_div (
        .clk(clk), .rst(rst), .tick(osc_tick), .load(load),
        .phase(phase), .clks(clks)
    );

    tc_window_gate #(.PERIOD(TICKS_PER_SEC), .HALF_WIN(HALF_WIN), .PH_W(PH_W)) u_gate (
        .clk(clk), .rst(rst), .phase(phase), .ref_pulse(ref_pulse),
        .win_open(win_open), .verdict(verdict), .fwd_q(fwd_pulse)
    );

    tc_miss_tracker #(.MISS_LIMIT(MISS_LIMIT), .MISS_W(MISS_W)) u_miss (
        .clk(clk), .rst(rst), .verdict(verdict),
        .miss_q(miss_count), .load(load), .resync_q(resync)
    );

    assign sec_clk = clks.sec;
    assign dbl_clk = clks.dbl;

    // R7: a re-phasing pulse is never forwarded
    a_r7_no_fwd_on_resync: assert property (@(posedge clk) disable iff (rst)
        !(fwd_pulse && resync));
    // R7: right after a re-phase the window is open and sec_clk low
    a_r7_edge_after_resync: assert property (@(posedge clk) disable iff (rst)
        resync |-> (win_open && !sec_clk));
endmodule

// File: tb/test_coarse_sync_timer.sv
module test_coarse_sync_timer;
    localparam int unsigned P  = 40;
    localparam int unsigned W  = 3;
    localparam int unsigned L  = 4;
    localparam int unsigned MW = (L + 1 < 2) ? 1 : $clog2(L + 1);

    typedef struct {
        logic sec, dbl, win, fwd, rsy;
        int   miss;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_tick = 1'b0;
    logic ref_pulse = 1'b0;
    logic sec_clk, dbl_clk, win_open, fwd_pulse, resync;
    logic [MW-1:0] miss_count;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    exp_t sb[$];
    int m_ph = 0;
    int m_miss = 0;

    always #5 clk = ~clk;

    coarse_sync_timer #(.TICKS_PER_SEC(P), .HALF_WIN(W), .MISS_LIMIT(L)) i_coarse_sync_timer (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .ref_pulse(ref_pulse),
        .sec_clk(sec_clk), .dbl_clk(dbl_clk), .win_open(win_open),
        .fwd_pulse(fwd_pulse), .miss_count(miss_count), .resync(resync)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic in_win(input int ph);
        return (ph <= int'(W)) || (ph >= int'(P - W));
    endfunction

    // driver: apply one cycle of stimulus and push the expected outputs
    task automatic step(input logic t, input logic p);
        exp_t e;
        osc_tick  = t;
        ref_pulse = p;
        @(posedge clk);
        e.fwd = 1'b0;
        e.rsy = 1'b0;
        if (p && in_win(m_ph)) begin
            e.fwd  = 1'b1;
            m_miss = 0;
        end else if (p) begin
            if (m_miss + 1 == int'(L)) begin
                e.rsy  = 1'b1;
                m_miss = 0;
            end else begin
                m_miss++;
            end
        end
        if (e.rsy) m_ph = 0;
        else if (t) m_ph = (m_ph == int'(P) - 1) ? 0 : m_ph + 1;
        e.sec  = (m_ph >= int'(P / 2));
        e.dbl  = ((m_ph % int'(P / 2)) >= int'(P / 4));
        e.win  = in_win(m_ph);
        e.miss = m_miss;
        sb.push_back(e);
        @(negedge clk);
        osc_tick  = 1'b0;
        ref_pulse = 1'b0;
    endtask

    // monitor: pop expected items and compare away from the active edge
    always @(negedge clk) begin
        if (mon_en && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check("R2 sec_clk", int'(sec_clk), int'(e.sec));
            check("R3 dbl_clk", int'(dbl_clk), int'(e.dbl));
            check("R4 win_open", int'(win_open), int'(e.win));
            check("R5 fwd_pulse", int'(fwd_pulse), int'(e.fwd));
            check("R6 miss_count", int'(miss_count), e.miss);
            check("R7 resync", int'(resync), int'(e.rsy));
        end
    end

    task automatic advance_to(input int target);
        while (m_ph != target) step(1'b1, 1'b0);
    endtask

    task automatic pulse_at(input int ph, input logic t);
        advance_to(ph);
        step(t, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 sec_clk", int'(sec_clk), 0);
        check("R1 dbl_clk", int'(dbl_clk), 0);
        check("R1 win_open", int'(win_open), 1);
        check("R1 miss_count", int'(miss_count), 0);
        check("R1 fwd_pulse", int'(fwd_pulse), 0);
        check("R1 resync", int'(resync), 0);
        mon_en = 1'b1;

        // R2/R3/R4: two full periods, dense then sparse ticks
        for (int i = 0; i < int'(P); i++) step(1'b1, 1'b0);
        for (int i = 0; i < int'(P) * 3; i++) step(i % 3 == 0, 1'b0);

        // R5: pulses on the falling edge and on both window edges
        pulse_at(0, 1'b1);
        pulse_at(int'(W), 1'b0);
        pulse_at(int'(P - W), 1'b1);

        // R6: just outside both edges counts a miss
        pulse_at(int'(W) + 1, 1'b1);
        check("R6 miss after late edge", int'(miss_count), 1);
        pulse_at(int'(P - W) - 1, 1'b1);
        check("R6 miss after early edge", int'(miss_count), 2);

        // R8: a long absence keeps the count
        for (int i = 0; i < int'(P) * 2; i++) step(1'b1, 1'b0);
        check("R8 count held", int'(miss_count), 2);

        // R5: one hit clears a partial run
        pulse_at(1, 1'b1);
        check("R5 hit clears run", int'(miss_count), 0);

        // R7: a run of misses re-phases the chain
        for (int k = 0; k < int'(L) - 1; k++) pulse_at(10 + k, 1'b1);
        pulse_at(17, 1'b0);
        check("R7 resync flag", int'(resync), 1);
        check("R7 fwd suppressed", int'(fwd_pulse), 0);
        check("R7 count cleared", int'(miss_count), 0);
        step(1'b1, 1'b0);
        check("R7 resync one cycle", int'(resync), 0);
        pulse_at(0, 1'b1);
        check("R7 next edge aligned", int'(fwd_pulse), 1);

        // R9: re-phase coinciding with a tick lands on phase 0
        for (int k = 0; k < int'(L); k++) pulse_at(20 + k, 1'b1);
        check("R9 resync with tick", int'(resync), 1);
        for (int i = 0; i < int'(W); i++) step(1'b1, 1'b0);
        check("R9 window still open", int'(win_open), 1);
        step(1'b1, 1'b0);
        check("R9 window closes", int'(win_open), 0);

        for (int i = 0; i < int'(P); i++) step(i % 2 == 0, 1'b0);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule